// File: doc/BRIEF.md
# Scatter-Gather List Walker

The walker resolves the data pointer of one storage command when that pointer is a scatter-gather list. It receives the first 16-byte descriptor and the total transfer length from the command. It fetches descriptor segments from host memory through a read-request and response port. The result is an ordered stream of (address, length) data entries for a later data mover. When the list ends, or a fault is found, the walker pulses `done` once and presents a 16-bit completion status.

Segments are read in bounded chunks of descriptors. The last descriptor of a segment either ends the list (when it is a data block) or points to the following segment. Descriptors are judged in the order they arrive. An error status means the command has failed, and the consumer discards any entries it has already received for that command. After a stop, the walker still accepts the rest of the chunk already requested, but it requests no more.

Descriptor layout (little-endian, 128 bits): bits [63:0] address, [95:64] length in bytes, [119:96] reserved, [127:120] type byte. The type is bits [127:124] and the subtype is bits [123:120]. Type codes: 0x0 data block, 0x1 bit bucket, 0x2 segment, 0x3 last segment, 0x4 keyed data block, 0xF vendor specific.

Top module: `sgl_walker`

## Requirements
- R1: After reset, `done`, `entry_valid` and `rd_req_valid` are 0 and `status` is 0x0000.
- R2: A first descriptor of type data block becomes the only entry. No memory request is made.
- R3: A descriptor used as a segment pointer must meet three conditions, or the walk ends with code 0x0D and no fetch of it:
  - its type is 0x2 or 0x3;
  - its length is nonzero;
  - its length is a multiple of 16.
- R4: A segment of N descriptors is read as requests of min(remaining count, CHUNK) descriptors, with CHUNK = 256 by default. Each request's address is 16·CHUNK bytes above the previous one. One response beat carries one descriptor.
- R5: When the final descriptor of a segment is a data block, it is mapped and the walk ends. Otherwise it is not mapped, and it becomes the pointer to the next segment.
- R6: A segment reached through a last-segment (0x3) pointer whose final descriptor is not a data block ends the walk with code 0x0D.
- R7: A descriptor in a data position with type 0x2 or 0x3 gives code 0x0E. Any other non-data type in a data position gives code 0x11.
- R8: Data descriptors of zero length emit nothing. Each entry's length is min(remaining transfer length, descriptor length), and that amount is taken off the remaining length.
- R9: A nonzero-length data descriptor met when the remaining length is zero behaves as follows:
  - if `allow_excess` is 1, the walk ends with status 0x0000;
  - if `allow_excess` is 0, the walk ends with code 0x0F.
- R10: Code 0x0F is given in two cases:
  - a descriptor whose address plus length reaches or passes 2^64;
  - any transfer length still unmapped when the list ends.
- R11: A response beat flagged `rsp_err` ends the walk with status 0x0004, with do-not-retry clear.
- R12: `status` carries the code in bits [7:0] and do-not-retry in bit 14. Bit 14 is set for every code except 0x00 and 0x04. `done` pulses for exactly one cycle per command, and no entry appears after `done` until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk; accepted while idle |
| first_desc | input | 128 | First descriptor from the command |
| xfer_len | input | LEN_W | Total transfer length in bytes |
| allow_excess | input | 1 | Accept descriptors beyond the transfer length |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Request accepted |
| rd_req_addr | output | 64 | Byte address of the first descriptor requested |
| rd_req_count | output | clog2(CHUNK+1) | Number of descriptors requested |
| rsp_valid | input | 1 | One descriptor returned |
| rsp_data | input | 128 | Returned descriptor |
| rsp_err | input | 1 | The returned beat failed |
| entry_valid | output | 1 | Data entry strobe |
| entry_addr | output | 64 | Entry address |
| entry_len | output | 32 | Entry length in bytes |
| done | output | 1 | Walk finished, one cycle |
| status | output | 16 | Completion status |

## Verification
Each entry appears in the cycle after the clock edge that accepts its descriptor. For a first descriptor that is a data block, the entry appears two edges after `start`, in the same cycle as `done`. `done` rises one edge after the last beat is accepted or the deciding check is made. A request is presented one edge after its segment pointer is checked. The bench samples every output two nanoseconds after the rising edge, logs entries, requests and completions in order, and compares the logs with lists worked out from the requirements. It waits a few extra cycles after each `done` to prove that nothing more arrives.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
   localparam int DESC_W = 128;

   localparam logic [3:0] SGT_DATA  = 4'h0;
   localparam logic [3:0] SGT_BITB  = 4'h1;
   localparam logic [3:0] SGT_SEG   = 4'h2;
   localparam logic [3:0] SGT_LAST  = 4'h3;
   localparam logic [3:0] SGT_KEYED = 4'h4;
   localparam logic [3:0] SGT_VEND  = 4'hF;

   localparam logic [7:0] ST_OK       = 8'h00;
   localparam logic [7:0] ST_XFER     = 8'h04;
   localparam logic [7:0] ST_BAD_SEG  = 8'h0D;
   localparam logic [7:0] ST_BAD_NUM  = 8'h0E;
   localparam logic [7:0] ST_BAD_LEN  = 8'h0F;
   localparam logic [7:0] ST_BAD_TYPE = 8'h11;

   localparam int DNR_BIT = 14;

   typedef struct packed {
      logic [7:0]  type_byte;
      logic [23:0] rsvd;
      logic [31:0] len;
      logic [63:0] addr;
   } sgl_desc_t;

   typedef enum logic [1:0] {
      DA_SKIP = 2'd0,
      DA_EMIT = 2'd1,
      DA_STOP = 2'd2,
      DA_FAIL = 2'd3
   } data_act_e;

   function automatic logic [15:0] mk_status(input logic [7:0] code);
      logic [15:0] s;
      s = {8'h00, code};
      s[DNR_BIT] = (code != ST_OK) && (code != ST_XFER);
      return s;
   endfunction

   function automatic logic addr_wraps(input logic [63:0] a, input logic [31:0] l);
      logic [64:0] sum;
      sum = {1'b0, a} + {33'b0, l};
      return sum[64];
   endfunction
endpackage

// File: rtl/sgl_data_eval.sv
module sgl_data_eval
   import sgl_pkg::*;
#(
   parameter int LEN_W = 32
) (
   input  sgl_desc_t        desc,
   input  logic [LEN_W-1:0] rem,
   input  logic             allow_excess,
   output data_act_e        act,
   output logic [7:0]       code,
   output logic [31:0]      emit_len,
   output logic [LEN_W-1:0] rem_next
);
   logic [3:0]  typ;
   logic [63:0] rem_w;
   logic [63:0] len_w;
   logic [63:0] take;

   assign typ   = desc.type_byte[7:4];
   assign rem_w = 64'(rem);
   assign len_w = 64'(desc.len);
   assign take  = (rem_w < len_w) ? rem_w : len_w;

   always_comb begin
      act      = DA_SKIP;
      code     = ST_OK;
      emit_len = '0;
      rem_next = rem;
      if (typ == SGT_SEG || typ == SGT_LAST) begin
         act  = DA_FAIL;
         code = ST_BAD_NUM;
      end else if (typ != SGT_DATA) begin
         act  = DA_FAIL;
         code = ST_BAD_TYPE;
      end else if (desc.len == 32'd0) begin
         act = DA_SKIP;
      end else if (rem == '0) begin
         if (allow_excess) begin
            act = DA_STOP;
         end else begin
            act  = DA_FAIL;
            code = ST_BAD_LEN;
         end
      end else if (addr_wraps(desc.addr, desc.len)) begin
         act  = DA_FAIL;
         code = ST_BAD_LEN;
      end else begin
         act      = DA_EMIT;
         emit_len = 32'(take);
         rem_next = rem - LEN_W'(take);
      end
   end
endmodule

// File: rtl/sgl_seg_eval.sv
module sgl_seg_eval
   import sgl_pkg::*;
#(
   parameter int CNT_W = 28
) (
   input  sgl_desc_t        desc,
   output logic             ok,
   output logic [7:0]       code,
   output logic             is_last,
   output logic [CNT_W-1:0] ndesc
);
   logic [3:0] typ;

   assign typ     = desc.type_byte[7:4];
   assign is_last = (typ == SGT_LAST);
   assign ndesc   = CNT_W'(desc.len[31:4]);

   always_comb begin
      ok   = 1'b1;
      code = ST_OK;
      if (typ != SGT_SEG && typ != SGT_LAST) begin
         ok   = 1'b0;
         code = ST_BAD_SEG;
      end else if (desc.len == 32'd0 || desc.len[3:0] != 4'd0) begin
         ok   = 1'b0;
         code = ST_BAD_SEG;
      end else if (addr_wraps(desc.addr, desc.len)) begin
         ok   = 1'b0;
         code = ST_BAD_LEN;
      end
   end
endmodule

// File: rtl/sgl_chunk_ctr.sv
module sgl_chunk_ctr #(
   parameter int CHUNK = 256,
   parameter int CNT_W = 28,
   parameter int RC_W  = $clog2(CHUNK + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [63:0]      base,
   input  logic [CNT_W-1:0] count,
   input  logic             take,
   input  logic             beat,
   output logic [63:0]      req_addr,
   output logic [RC_W-1:0]  req_cnt,
   output logic             seg_empty,
   output logic             chunk_last
);
   localparam logic [63:0]      STEP    = 64'(CHUNK) << 4;
   localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK);

   logic [63:0]      addr_q;
   logic [CNT_W-1:0] left_q;
   logic [RC_W-1:0]  beats_q;

   assign req_addr   = addr_q;
   assign req_cnt    = (left_q > CHUNK_C) ? RC_W'(CHUNK) : RC_W'(left_q);
   assign seg_empty  = (left_q == '0);
   assign chunk_last = (beats_q == RC_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         left_q  <= '0;
         beats_q <= '0;
      end else if (load) begin
         addr_q  <= base;
         left_q  <= count;
         beats_q <= '0;
      end else if (take) begin
         addr_q  <= addr_q + STEP;
         left_q  <= left_q - CNT_W'(req_cnt);
         beats_q <= req_cnt;
      end else if (beat && beats_q != '0) begin
         beats_q <= beats_q - RC_W'(1);
      end
   end
endmodule

// File: rtl/sgl_walker.sv
module sgl_walker
   import sgl_pkg::*;
#(
   parameter int LEN_W = 32,
   parameter int CHUNK = 256
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [127:0]                 first_desc,
   input  logic [LEN_W-1:0]             xfer_len,
   input  logic                         allow_excess,
   output logic                         rd_req_valid,
   input  logic                         rd_req_ready,
   output logic [63:0]                  rd_req_addr,
   output logic [$clog2(CHUNK+1)-1:0]   rd_req_count,
   input  logic                         rsp_valid,
   input  logic [127:0]                 rsp_data,
   input  logic                         rsp_err,
   output logic                         entry_valid,
   output logic [63:0]                  entry_addr,
   output logic [31:0]                  entry_len,
   output logic                         done,
   output logic [15:0]                  status
);
   localparam int RC_W  = $clog2(CHUNK + 1);
   localparam int CNT_W = 28;

   if (LEN_W < 8 || LEN_W > 64) begin : g_bad_len_w
      $error("sgl_walker: LEN_W must lie in 8..64");
   end
   if (CHUNK < 1 || CHUNK > 4096) begin : g_bad_chunk
      $error("sgl_walker: CHUNK must lie in 1..4096");
   end

   typedef enum logic [2:0] {
      S_IDLE, S_INIT, S_SEG, S_REQ, S_RECV, S_DRAIN
   } walk_state_e;

   walk_state_e      state, nstate;
   sgl_desc_t        cur_desc;
   sgl_desc_t        rsp_desc;
   sgl_desc_t        ev_desc;
   logic [LEN_W-1:0] rem;
   logic             allow_r;
   logic             in_last;
   logic [7:0]       pend_code;

   data_act_e        ev_act;
   logic [7:0]       ev_code;
   logic [31:0]      ev_len;
   logic [LEN_W-1:0] ev_rem_next;

   logic             sg_ok, sg_last;
   logic [7:0]       sg_code;
   logic [CNT_W-1:0] sg_ndesc;

   logic             ck_load, ck_take, ck_beat;
   logic             seg_empty, chunk_last, seg_end;

   logic             fin, emit, grab, pend_set, stop;
   logic [7:0]       fin_code, scode;

   assign rsp_desc = sgl_desc_t'(rsp_data);
   assign ev_desc  = (state == S_RECV) ? rsp_desc : cur_desc;
   assign seg_end  = chunk_last && seg_empty;

   sgl_data_eval #(.LEN_W(LEN_W)) u_data (
      .desc         (ev_desc),
      .rem          (rem),
      .allow_excess (allow_r),
      .act          (ev_act),
      .code         (ev_code),
      .emit_len     (ev_len),
      .rem_next     (ev_rem_next)
   );

   sgl_seg_eval #(.CNT_W(CNT_W)) u_seg (
      .desc    (cur_desc),
      .ok      (sg_ok),
      .code    (sg_code),
      .is_last (sg_last),
      .ndesc   (sg_ndesc)
   );

   assign ck_load = (state == S_SEG) && sg_ok;
   assign ck_take = (state == S_REQ) && rd_req_ready;
   assign ck_beat = ((state == S_RECV) || (state == S_DRAIN)) && rsp_valid;

   sgl_chunk_ctr #(.CHUNK(CHUNK), .CNT_W(CNT_W), .RC_W(RC_W)) u_chunk (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ck_load),
      .base       (cur_desc.addr),
      .count      (sg_ndesc),
      .take       (ck_take),
      .beat       (ck_beat),
      .req_addr   (rd_req_addr),
      .req_cnt    (rd_req_count),
      .seg_empty  (seg_empty),
      .chunk_last (chunk_last)
   );

   assign rd_req_valid = (state == S_REQ);

   always_comb begin
      nstate   = state;
      fin      = 1'b0;
      fin_code = ST_OK;
      emit     = 1'b0;
      grab     = 1'b0;
      pend_set = 1'b0;
      stop     = 1'b0;
      scode    = ST_OK;
      case (state)
         S_IDLE: if (start) nstate = S_INIT;
         S_INIT: begin
            if (cur_desc.type_byte[7:4] == SGT_DATA) begin
               fin = 1'b1;
               case (ev_act)
                  DA_EMIT: begin
                     emit     = 1'b1;
                     fin_code = (ev_rem_next == '0) ? ST_OK : ST_BAD_LEN;
                  end
                  DA_SKIP: fin_code = (rem == '0) ? ST_OK : ST_BAD_LEN;
                  DA_STOP: fin_code = ST_OK;
                  default: fin_code = ev_code;
               endcase
            end else begin
               nstate = S_SEG;
            end
         end
         S_SEG: begin
            if (sg_ok) begin
               nstate = S_REQ;
            end else begin
               fin      = 1'b1;
               fin_code = sg_code;
            end
         end
         S_REQ: if (rd_req_ready) nstate = S_RECV;
         S_RECV: begin
            if (rsp_valid) begin
               if (rsp_err) begin
                  stop  = 1'b1;
                  scode = ST_XFER;
               end else if (seg_end && rsp_desc.type_byte[7:4] != SGT_DATA) begin
                  if (in_last) begin
                     fin      = 1'b1;
                     fin_code = ST_BAD_SEG;
                  end else begin
                     grab   = 1'b1;
                     nstate = S_SEG;
                  end
               end else begin
                  case (ev_act)
                     DA_FAIL: begin
                        stop  = 1'b1;
                        scode = ev_code;
                     end
                     DA_STOP: stop = 1'b1;
                     default: begin
                        emit = (ev_act == DA_EMIT);
                        if (seg_end) begin
                           fin      = 1'b1;
                           fin_code = (ev_rem_next == '0) ? ST_OK : ST_BAD_LEN;
                        end else if (chunk_last) begin
                           nstate = S_REQ;
                        end
                     end
                  endcase
               end
               if (stop) begin
                  if (chunk_last) begin
                     fin      = 1'b1;
                     fin_code = scode;
                  end else begin
                     pend_set = 1'b1;
                     nstate   = S_DRAIN;
                  end
               end
            end
         end
         S_DRAIN: begin
            if (rsp_valid && chunk_last) begin
               fin      = 1'b1;
               fin_code = pend_code;
            end
         end
         default: nstate = S_IDLE;
      endcase
      if (fin) nstate = S_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         cur_desc    <= '0;
         rem         <= '0;
         allow_r     <= 1'b0;
         in_last     <= 1'b0;
         pend_code   <= ST_OK;
         entry_valid <= 1'b0;
         entry_addr  <= '0;
         entry_len   <= '0;
         done        <= 1'b0;
         status      <= '0;
      end else begin
         state       <= nstate;
         done        <= fin;
         entry_valid <= emit;
         if (fin) status <= mk_status(fin_code);
         if (emit) begin
            entry_addr <= ev_desc.addr;
            entry_len  <= ev_len;
            rem        <= ev_rem_next;
         end
         if (state == S_IDLE && start) begin
            cur_desc <= sgl_desc_t'(first_desc);
            rem      <= xfer_len;
            allow_r  <= allow_excess;
            in_last  <= 1'b0;
         end
         if (grab) cur_desc <= rsp_desc;
         if (ck_load) in_last <= sg_last;
         if (pend_set) pend_code <= scode;
      end
   end
endmodule

// File: rtl/sgl_walker_chk.sv
module sgl_walker_chk #(
   parameter int CHUNK = 256
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start,
   input logic                       rd_req_valid,
   input logic                       rd_req_ready,
   input logic [63:0]                rd_req_addr,
   input logic [$clog2(CHUNK+1)-1:0] rd_req_count,
   input logic                       entry_valid,
   input logic [31:0]                entry_len,
   input logic                       done,
   input logic [15:0]                status
);
   logic finished;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) finished <= 1'b1;
      else if (start) finished <= 1'b0;
      else if (done) finished <= 1'b1;
   end

   AST_REQ_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> (rd_req_count != '0) && (32'(rd_req_count) <= CHUNK)); // R4

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R4

   AST_ENTRY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      entry_valid |-> entry_len != 32'd0); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12

   AST_DNR_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> status[14] == ((status[7:0] != 8'h00) && (status[7:0] != 8'h04))); // R12

   AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      entry_valid |-> !finished); // R12

   AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> !finished); // R12
endmodule

bind sgl_walker sgl_walker_chk #(.CHUNK(CHUNK)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .rd_req_valid (rd_req_valid),
   .rd_req_ready (rd_req_ready),
   .rd_req_addr  (rd_req_addr),
   .rd_req_count (rd_req_count),
   .entry_valid  (entry_valid),
   .entry_len    (entry_len),
   .done         (done),
   .status       (status)
);

// File: tb/tb_sgl_walker.sv
`timescale 1ns/1ps
module tb_sgl_walker;
   localparam logic [63:0] MB = 64'h0001_0000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] first_desc = '0;
   logic [31:0]  xfer_len = '0;
   logic         allow_excess = 1'b0;
   logic         rd_req_valid;
   logic         rd_req_ready = 1'b1;
   logic [63:0]  rd_req_addr;
   logic [8:0]   rd_req_count;
   logic         rsp_valid = 1'b0;
   logic [127:0] rsp_data = '0;
   logic         rsp_err = 1'b0;
   logic         entry_valid;
   logic [63:0]  entry_addr;
   logic [31:0]  entry_len;
   logic         done;
   logic [15:0]  status;

   always #5 clk = ~clk;

   sgl_walker dut (.*);

   logic [127:0] mem [512];
   int           err_idx = 9999;
   int           rs_idx = 0;
   int           rs_left = 0;

   int           n_checks = 0;
   int           n_errors = 0;
   int           ent_n, req_n, done_n;
   logic [63:0]  ent_addr [16];
   logic [31:0]  ent_len  [16];
   logic [63:0]  req_addr [8];
   int           req_cnt  [8];
   logic [15:0]  last_status;

   function automatic logic [127:0] mkd(input logic [3:0] t, input logic [63:0] a,
                                        input logic [31:0] l);
      return {t, 4'h0, 24'h0, l, a};
   endfunction

   function automatic logic [63:0] at(input int i);
      return MB + 64'(i) * 64'd16;
   endfunction

   // memory responder: one descriptor per cycle, driven on the falling edge
   always @(negedge clk) begin
      if (rs_left > 0) begin
         rsp_valid <= 1'b1;
         rsp_data  <= (rs_idx < 512) ? mem[rs_idx] : '0;
         rsp_err   <= (rs_idx == err_idx);
         rs_idx    = rs_idx + 1;
         rs_left   = rs_left - 1;
      end else begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
      end
      if (rd_req_valid && rd_req_ready) begin
         rs_idx  = int'((rd_req_addr - MB) >> 4);
         rs_left = int'(rd_req_count);
         if (req_n < 8) begin
            req_addr[req_n] = rd_req_addr;
            req_cnt[req_n]  = int'(rd_req_count);
         end
         req_n = req_n + 1;
      end
   end

   // output monitor, sampled 2 ns after the rising edge
   always @(posedge clk) begin
      #2;
      if (entry_valid) begin
         if (ent_n < 16) begin
            ent_addr[ent_n] = entry_addr;
            ent_len[ent_n]  = entry_len;
         end
         ent_n = ent_n + 1;
      end
      if (done) begin
         done_n      = done_n + 1;
         last_status = status;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input logic [127:0] d, input logic [31:0] len, input logic ax);
      int waited;
      ent_n  = 0;
      req_n  = 0;
      done_n = 0;
      @(negedge clk);
      start        = 1'b1;
      first_desc   = d;
      xfer_len     = len;
      allow_excess = ax;
      @(negedge clk);
      start  = 1'b0;
      waited = 0;
      while (done_n == 0 && waited < 3000) begin
         @(negedge clk);
         waited++;
      end
      if (done_n == 0) begin
         n_checks++;
         n_errors++;
         $display("FAIL R12: actual no done expected done within 3000 cycles");
      end
      repeat (4) @(negedge clk);
      chk("R12 single done", 64'(done_n), 64'd1);
   endtask

   task automatic t_reset;
      chk("R1 done", 64'(done), 64'd0);
      chk("R1 entry_valid", 64'(entry_valid), 64'd0);
      chk("R1 rd_req_valid", 64'(rd_req_valid), 64'd0);
      chk("R1 status", 64'(status), 64'h0);
   endtask

   task automatic t_direct;
      run(mkd(4'h0, 64'h1234_0000, 32'h200), 32'h200, 1'b0);
      chk("R2 status", 64'(last_status), 64'h0000);
      chk("R2 entries", 64'(ent_n), 64'd1);
      chk("R2 addr", ent_addr[0], 64'h1234_0000);
      chk("R2 len", 64'(ent_len[0]), 64'h200);
      chk("R2 no fetch", 64'(req_n), 64'd0);
      run(mkd(4'h0, 64'h1234_0000, 32'h200), 32'h300, 1'b0);
      chk("R10 residual direct", 64'(last_status), 64'h400F);
      run(mkd(4'h0, 64'hFFFF_FFFF_FFFF_FF00, 32'h100), 32'h100, 1'b0);
      chk("R10 wrap", 64'(last_status), 64'h400F);
      chk("R10 wrap entries", 64'(ent_n), 64'd0);
   endtask

   task automatic t_seg_rules;
      run(mkd(4'h2, at(0), 32'h18), 32'h100, 1'b0);
      chk("R3 len not multiple", 64'(last_status), 64'h400D);
      chk("R3 no fetch", 64'(req_n), 64'd0);
      run(mkd(4'h3, at(0), 32'h0), 32'h100, 1'b0);
      chk("R3 zero len", 64'(last_status), 64'h400D);
      run(mkd(4'h1, at(0), 32'h10), 32'h100, 1'b0);
      chk("R3 bad type", 64'(last_status), 64'h400D);
      run(mkd(4'h2, 64'hFFFF_FFFF_FFFF_FFF0, 32'h20), 32'h100, 1'b0);
      chk("R10 seg wrap", 64'(last_status), 64'h400F);
   endtask

   task automatic t_chain;
      mem[0] = mkd(4'h0, 64'h2000, 32'h100);
      mem[1] = mkd(4'h0, 64'h3000, 32'h0);
      mem[2] = mkd(4'h3, at(8), 32'h20);
      mem[8] = mkd(4'h0, 64'h4000, 32'h80);
      mem[9] = mkd(4'h0, 64'h5000, 32'h100);
      run(mkd(4'h2, at(0), 32'h30), 32'h280, 1'b0);
      chk("R5 status", 64'(last_status), 64'h0000);
      chk("R5 entries", 64'(ent_n), 64'd3);
      chk("R5 e0", {ent_addr[0][31:0], ent_len[0]}, {32'h2000, 32'h100});
      chk("R8 skip zero", {ent_addr[1][31:0], ent_len[1]}, {32'h4000, 32'h80});
      chk("R5 e2", {ent_addr[2][31:0], ent_len[2]}, {32'h5000, 32'h100});
      chk("R5 requests", 64'(req_n), 64'd2);
      chk("R5 second seg addr", req_addr[1], at(8));
      chk("R4 counts", {32'(req_cnt[0]), 32'(req_cnt[1])}, {32'd3, 32'd2});
   endtask

   task automatic t_lengths;
      mem[16] = mkd(4'h0, 64'h6000, 32'h100);
      mem[17] = mkd(4'h0, 64'h7000, 32'h100);
      run(mkd(4'h3, at(16), 32'h20), 32'h180, 1'b0);
      chk("R8 status", 64'(last_status), 64'h0000);
      chk("R8 min len", {ent_addr[1][31:0], ent_len[1]}, {32'h7000, 32'h80});
      run(mkd(4'h3, at(16), 32'h20), 32'h100, 1'b0);
      chk("R9 excess refused", 64'(last_status), 64'h400F);
      run(mkd(4'h3, at(16), 32'h20), 32'h100, 1'b1);
      chk("R9 excess allowed", 64'(last_status), 64'h0000);
      chk("R9 entries", 64'(ent_n), 64'd1);
      run(mkd(4'h3, at(16), 32'h20), 32'h300, 1'b0);
      chk("R10 residual", 64'(last_status), 64'h400F);
      chk("R10 residual entries", 64'(ent_n), 64'd2);
   endtask

   task automatic t_last_seg;
      mem[16] = mkd(4'h0, 64'h6000, 32'h100);
      mem[17] = mkd(4'h2, at(8), 32'h20);
      run(mkd(4'h3, at(16), 32'h20), 32'h200, 1'b0);
      chk("R6 status", 64'(last_status), 64'h400D);
      chk("R6 no further fetch", 64'(req_n), 64'd1);
   endtask

   task automatic t_types;
      mem[24] = mkd(4'h0, 64'h8000, 32'h40);
      mem[25] = mkd(4'h1, 64'h8800, 32'h40);
      mem[26] = mkd(4'h0, 64'h9000, 32'h40);
      mem[27] = mkd(4'h0, 64'hA000, 32'h40);
      run(mkd(4'h3, at(24), 32'h40), 32'h100, 1'b0);
      chk("R7 other type", 64'(last_status), 64'h4011);
      chk("R7 entries stop", 64'(ent_n), 64'd1);
      mem[25] = mkd(4'h2, 64'h8800, 32'h40);
      run(mkd(4'h3, at(24), 32'h40), 32'h100, 1'b0);
      chk("R7 segment in data slot", 64'(last_status), 64'h400E);
      chk("R7 entries stop 2", 64'(ent_n), 64'd1);
   endtask

   task automatic t_chunks;
      for (int i = 100; i < 400; i++) mem[i] = mkd(4'h0, 64'h0, 32'h0);
      mem[100] = mkd(4'h0, 64'hB000, 32'h100);
      mem[360] = mkd(4'h0, 64'hC000, 32'h40);
      mem[399] = mkd(4'h0, 64'hD000, 32'h100);
      run(mkd(4'h3, at(100), 32'd4800), 32'h240, 1'b0);
      chk("R4 status", 64'(last_status), 64'h0000);
      chk("R4 requests", 64'(req_n), 64'd2);
      chk("R4 first", {req_addr[0], 64'(req_cnt[0])}, {at(100), 64'd256});
      chk("R4 second", {req_addr[1], 64'(req_cnt[1])}, {at(356), 64'd44});
      chk("R4 entries", 64'(ent_n), 64'd3);
      chk("R4 middle entry", ent_addr[1], 64'hC000);
   endtask

   task automatic t_xfer_err;
      mem[16] = mkd(4'h0, 64'h6000, 32'h100);
      mem[17] = mkd(4'h0, 64'h7000, 32'h100);
      err_idx = 17;
      run(mkd(4'h3, at(16), 32'h20), 32'h200, 1'b0);
      chk("R11 status", 64'(last_status), 64'h0004);
      chk("R11 entries", 64'(ent_n), 64'd1);
      mem[25] = mkd(4'h1, 64'h8800, 32'h40);
      err_idx = 24;
      run(mkd(4'h3, at(24), 32'h40), 32'h100, 1'b0);
      chk("R11 drained status", 64'(last_status), 64'h0004);
      chk("R11 drained entries", 64'(ent_n), 64'd0);
      err_idx = 9999;
   endtask

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = '0;
      ent_n  = 0;
      req_n  = 0;
      done_n = 0;
      last_status = '0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_direct;
      t_seg_rules;
      t_chain;
      t_lengths;
      t_last_seg;
      t_types;
      t_chunks;
      t_xfer_err;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #1_500_000;
      n_checks++;
      n_errors++;
      $display("FAIL R12: actual watchdog expired expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule